// File: doc/BRIEF.md
# Short-Address DMA Channel Controller

A single DMA channel that moves one byte or one 16-bit word per hardware request. An 8-bit control register arms the channel and selects the transfer size, the address direction, the operating mode and which of six peripheral request lines triggers it. The channel keeps a memory address register and a transfer counter. It latches the selected request pulse and raises a bus request that carries the current address and the size. When the bus acknowledges, it steps the address and the count.

The channel has three operating modes. In I/O mode it stops itself when the count runs out and can raise an end interrupt. Repeat mode restores the programmed address and count and keeps running. Idle mode keeps the address fixed and serves requests without end. Software writes the address and count registers, and each write also loads the restore copy that repeat and idle mode use.

Top module: `dma_short_chan`

## Requirements
- R1: After reset the control register, address and count read 0, and bus_req_o and irq_o are low.
- R2: The control register reads back what was written. The field positions are: bit 7 enable, bit 6 size (1 = word), bit 5 direction (1 = decrement), bit 4 repeat, bit 3 interrupt/idle, bits 2..0 source select.
- R3: While bit 7 is 0, request pulses raise no bus request and leave the address and the count unchanged.
- R4: Select code n (0..5) makes src_req_i[n] the only trigger. Codes 6 and 7 let no line trigger the channel.
- R5: A latched request raises bus_req_o two clock edges after its pulse. The request stays up until bus_ack_i, with bus_addr_o equal to the address register and bus_word_o equal to bit 6.
- R6: Each acknowledged transfer moves the address by 1 for bytes or by 2 for words, upward when bit 5 is 0 and downward when it is 1.
- R7: In I/O mode (bit 4 = 0) each transfer lowers the count by 1. The transfer that brings it to 0 clears bit 7, and later requests are ignored.
- R8: irq_o pulses for one cycle after the final I/O-mode transfer when bit 3 is 1. It stays low otherwise.
- R9: In repeat mode (bit 4 = 1, bit 3 = 0) the transfer that brings the count to 0 reloads the written count and address, and bit 7 stays set.
- R10: In idle mode (bits 4 and 3 both 1) the address never moves, the count reloads at 0 and bit 7 stays set.
- R11: Any number of request pulses during a transfer result in exactly one more transfer, which starts right after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register contents |
| mar_we_i | input | 1 | Address register write strobe (also loads the restore copy) |
| mar_wdata_i | input | AW | Address write data |
| mar_o | output | AW | Current address |
| cnt_we_i | input | 1 | Count write strobe (also loads the restore copy) |
| cnt_wdata_i | input | CW | Count write data |
| cnt_o | output | CW | Current count |
| src_req_i | input | NSRC | One-cycle request pulses, one per source |
| bus_req_o | output | 1 | Bus transfer request |
| bus_addr_o | output | AW | Transfer address |
| bus_word_o | output | 1 | 1 = word transfer, 0 = byte |
| bus_ack_i | input | 1 | Bus acknowledge, ends the transfer |
| irq_o | output | 1 | End-of-transfer interrupt pulse |

## Verification
A request pulse seen at clock edge k sets the latch at k and raises bus_req_o at edge k+1. The acknowledge seen at edge m updates the address, the count, bit 7 and irq_o at m, and a pending request raises bus_req_o again at m+1. The bench drives on the falling edge and samples each result at the falling edge that follows the rising edge where it is due. Ignored requests are checked by waiting two edges past the point where a transfer would have started, then reading the bus request, the address and the control register.

// File: rtl/dma_sa_pkg.sv
package dma_sa_pkg;
  typedef enum logic [1:0] {
    MODE_IO   = 2'd0,
    MODE_RPT  = 2'd1,
    MODE_IDLE = 2'd2
  } mode_e;

  typedef struct packed {
    logic       en;
    logic       word;
    logic       dec;
    logic       rpt;
    logic       ie;
    logic [2:0] sel;
  } cfg_t;

  function automatic mode_e mode_of(input cfg_t c);
    if (!c.rpt)     return MODE_IO;
    else if (!c.ie) return MODE_RPT;
    else            return MODE_IDLE;
  endfunction
endpackage

// File: rtl/dma_sa_cfg.sv
module dma_sa_cfg
  import dma_sa_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       hw_clr_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  // a software write in the same cycle wins over the hardware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (we_i)     cfg_q <= cfg_t'(wdata_i);
    else if (hw_clr_i) cfg_q.en <= 1'b0;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/dma_sa_req.sv
module dma_sa_req #(
  parameter int NSRC = 6,
  parameter int SW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_req_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            en_i,
  input  logic            take_i,
  output logic            pend_o
);
  logic [NSRC-1:0] sel_oh;
  logic            hit;
  logic            pend_q;

  // codes at or above NSRC decode to no source
  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign sel_oh[i] = (sel_i == SW'(i));
  end

  assign hit = |(sel_oh & src_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (!en_i)  pend_q <= 1'b0;
    else if (hit)    pend_q <= 1'b1;
    else if (take_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_sa_addr_cnt.sv
module dma_sa_addr_cnt
  import dma_sa_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mar_we_i,
  input  logic [AW-1:0] mar_wdata_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          done_i,
  input  logic          word_i,
  input  logic          dec_i,
  input  mode_e         mode_i,
  output logic [AW-1:0] mar_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [AW-1:0] mar_q, mar_init_q, mar_step, mar_d;
  logic [CW-1:0] cnt_q, cnt_init_q, cnt_d;
  logic          last;

  assign last     = (cnt_q == CW'(1));
  assign mar_step = dec_i ? (mar_q - (word_i ? AW'(2) : AW'(1)))
                          : (mar_q + (word_i ? AW'(2) : AW'(1)));

  always_comb begin
    mar_d = mar_q;
    cnt_d = cnt_q;
    if (done_i) begin
      unique case (mode_i)
        MODE_IO: begin
          mar_d = mar_step;
          cnt_d = cnt_q - CW'(1);
        end
        MODE_RPT: begin
          mar_d = last ? mar_init_q : mar_step;
          cnt_d = last ? cnt_init_q : cnt_q - CW'(1);
        end
        default: begin
          cnt_d = last ? cnt_init_q : cnt_q - CW'(1);
        end
      endcase
    end
    if (mar_we_i) mar_d = mar_wdata_i;
    if (cnt_we_i) cnt_d = cnt_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q      <= '0;
      cnt_q      <= '0;
      mar_init_q <= '0;
      cnt_init_q <= '0;
    end else begin
      mar_q <= mar_d;
      cnt_q <= cnt_d;
      if (mar_we_i) mar_init_q <= mar_wdata_i;
      if (cnt_we_i) cnt_init_q <= cnt_wdata_i;
    end
  end

  assign mar_o  = mar_q;
  assign cnt_o  = cnt_q;
  assign last_o = last;
endmodule

// File: rtl/dma_short_chan.sv
module dma_short_chan
  import dma_sa_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int NSRC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  output logic [7:0]      cfg_rdata_o,
  input  logic            mar_we_i,
  input  logic [AW-1:0]   mar_wdata_i,
  output logic [AW-1:0]   mar_o,
  input  logic            cnt_we_i,
  input  logic [CW-1:0]   cnt_wdata_i,
  output logic [CW-1:0]   cnt_o,
  input  logic [NSRC-1:0] src_req_i,
  output logic            bus_req_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic            bus_word_o,
  input  logic            bus_ack_i,
  output logic            irq_o
);
  localparam int SW = 3;

  cfg_t  cfg;
  mode_e mode;
  logic  pend, busy_q, take, done, last, hw_clr, irq_q;

  assign mode   = mode_of(cfg);
  assign take   = pend & cfg.en & ~busy_q;
  assign done   = busy_q & bus_ack_i;
  assign hw_clr = done & last & (mode == MODE_IO);

  dma_sa_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .hw_clr_i(hw_clr),
    .cfg_o   (cfg)
  );

  dma_sa_req #(.NSRC(NSRC), .SW(SW)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_req_i(src_req_i),
    .sel_i    (cfg.sel),
    .en_i     (cfg.en),
    .take_i   (take),
    .pend_o   (pend)
  );

  dma_sa_addr_cnt #(.AW(AW), .CW(CW)) u_ac (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mar_we_i   (mar_we_i),
    .mar_wdata_i(mar_wdata_i),
    .cnt_we_i   (cnt_we_i),
    .cnt_wdata_i(cnt_wdata_i),
    .done_i     (done),
    .word_i     (cfg.word),
    .dec_i      (cfg.dec),
    .mode_i     (mode),
    .mar_o      (mar_o),
    .cnt_o      (cnt_o),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (take)      busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      irq_q <= hw_clr & cfg.ie;
    end
  end

  assign cfg_rdata_o = cfg;
  assign bus_req_o   = busy_q;
  assign bus_addr_o  = mar_o;
  assign bus_word_o  = cfg.word;
  assign irq_o       = irq_q;
endmodule

// File: rtl/dma_sa_chk.sv
module dma_sa_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [7:0]    cfg_rdata_o,
  input logic          mar_we_i,
  input logic [AW-1:0] mar_o,
  input logic          bus_req_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_word_o,
  input logic          bus_ack_i,
  input logic          irq_o
);
  // R5: request held until acknowledged
  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o);

  // R5: address and size steady during a transfer
  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !mar_we_i && !cfg_we_i |=> $stable(bus_addr_o) && $stable(bus_word_o));

  // R3: a new transfer starts only while enabled
  a_r3_start_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> $past(cfg_rdata_o[7]));

  // R8: interrupt only right after an acknowledged transfer, with enable cleared
  a_r8_irq_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(bus_req_o && bus_ack_i));

  a_r8_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r7_irq_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(cfg_we_i) |-> !cfg_rdata_o[7]);

  // R10: idle mode keeps the address
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && cfg_rdata_o[4] && cfg_rdata_o[3] && !mar_we_i
    |=> $stable(mar_o));
endmodule

bind dma_short_chan dma_sa_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_rdata_o(cfg_rdata_o),
  .mar_we_i   (mar_we_i),
  .mar_o      (mar_o),
  .bus_req_o  (bus_req_o),
  .bus_addr_o (bus_addr_o),
  .bus_word_o (bus_word_o),
  .bus_ack_i  (bus_ack_i),
  .irq_o      (irq_o)
);

// File: tb/sim_dma_short_chan.sv
`timescale 1ns/1ps
module sim_dma_short_chan;
  localparam int AW = 16, CW = 8, NSRC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, mar_we = 1'b0, cnt_we = 1'b0, ack = 1'b0;
  logic [7:0] cfg_wd = '0, cfg_rd;
  logic [AW-1:0] mar_wd = '0, mar, addr;
  logic [CW-1:0] cnt_wd = '0, cnt;
  logic [NSRC-1:0] src = '0;
  logic breq, bword, irq;
  int n_run = 0, n_fail = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  dma_short_chan #(.AW(AW), .CW(CW), .NSRC(NSRC)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd),
    .mar_we_i(mar_we), .mar_wdata_i(mar_wd), .mar_o(mar),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .cnt_o(cnt),
    .src_req_i(src), .bus_req_o(breq), .bus_addr_o(addr),
    .bus_word_o(bword), .bus_ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wd = v; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic wr_mc(input logic [AW-1:0] m, input logic [CW-1:0] c);
    @(negedge clk) begin mar_we = 1'b1; mar_wd = m; cnt_we = 1'b1; cnt_wd = c; end
    @(negedge clk) begin mar_we = 1'b0; cnt_we = 1'b0; end
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk) src = m;
    @(negedge clk) src = '0;
  endtask

  task automatic do_ack;
    ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cfg_rd == 8'h00 && mar == '0 && cnt == '0 && !breq && !irq, "R1",
        {cfg_rd, breq, irq}, 0);
    rst_n = 1'b1;

    // R2 readback
    wr_cfg(8'h5A); chk(cfg_rd == 8'h5A, "R2", cfg_rd, 8'h5A);
    wr_cfg(8'h27); chk(cfg_rd == 8'h27, "R2", cfg_rd, 8'h27);

    // R3 disabled: requests ignored
    wr_mc(16'h0800, 8'd4);
    wr_cfg(8'h01);
    pulse(6'h3F); @(negedge clk); @(negedge clk);
    chk(!breq && mar == 16'h0800 && cnt == 8'd4, "R3", {breq, mar}, 16'h0800);

    // R4 codes 6 and 7 select nothing
    for (int c = 6; c < 8; c++) begin
      wr_cfg(8'h80 | 8'(c));
      pulse(6'h3F); @(negedge clk); @(negedge clk);
      chk(!breq && mar == 16'h0800, "R4", breq, 0);
    end

    // sweep: mode x size x direction x source
    for (int m = 0; m < 4; m++)
      for (int sz = 0; sz < 2; sz++)
        for (int dr = 0; dr < 2; dr++)
          for (int s = 0; s < NSRC; s++) begin
            automatic bit io = (m < 2), ie = (m == 1 || m == 3), idle = (m == 3);
            automatic int step = sz ? 2 : 1;
            automatic logic [7:0] v = {1'b1, sz[0], dr[0], ~io, ie, 3'(s)};
            wr_cfg(8'h00);
            wr_mc(16'h1000, 8'd3);
            wr_cfg(v);
            pulse(6'(1 << ((s + 1) % NSRC))); @(negedge clk);
            chk(!breq, "R4", breq, 0);
            for (int i = 0; i < 4; i++) begin
              automatic int k  = idle ? 0 : (io ? i : i % 3);
              automatic int k1 = idle ? 0 : (io ? i + 1 : (i + 1) % 3);
              automatic logic [AW-1:0] ea = dr ? AW'(16'h1000 - k * step) : AW'(16'h1000 + k * step);
              automatic logic [AW-1:0] em = dr ? AW'(16'h1000 - k1 * step) : AW'(16'h1000 + k1 * step);
              automatic int ec = io ? 2 - i : ((i % 3 == 2) ? 3 : 2 - (i % 3));
              pulse(6'(1 << s)); @(negedge clk);
              if (io && i == 3) begin
                chk(!breq && mar == ea && !cfg_rd[7], "R7", {breq, cfg_rd[7]}, 0);
              end else begin
                chk(breq && addr == ea && bword == sz[0], "R5", addr, ea);
                do_ack;
                chk(mar == em, idle ? "R10" : "R6", mar, em);
                chk(cnt == CW'(ec), io ? "R7" : "R9", cnt, ec);
                chk(irq == (io && ie && i == 2), "R8", irq, io && ie && i == 2);
                chk(cfg_rd[7] == !(io && i == 2), io ? "R7" : "R9", cfg_rd[7], !(io && i == 2));
              end
            end
          end

    // R11 requests during a transfer collapse to one
    wr_cfg(8'h00);
    wr_mc(16'h2000, 8'd5);
    wr_cfg(8'h80);
    pulse(6'h01); @(negedge clk);
    chk(breq && addr == 16'h2000, "R11", addr, 16'h2000);
    pulse(6'h01); pulse(6'h01);
    chk(breq && addr == 16'h2000, "R11", addr, 16'h2000);
    do_ack;
    chk(!breq, "R11", breq, 0);
    @(negedge clk);
    chk(breq && addr == 16'h2001, "R11", addr, 16'h2001);
    do_ack;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(!breq && cnt == 8'd3 && mar == 16'h2002, "R11", cnt, 3);

    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end
endmodule